// File: doc/BRIEF.md
# Double-Edge 16:1 Word Serializer

The block turns a 16-bit parallel word into a single serial stream. A half-rate clock drives it, and one serial bit goes out on each edge of that clock, so the stream runs at twice the clock frequency. Each word therefore takes eight half-rate cycles to send.

A chain of three divide-by-2 stages on the half-rate clock sets the pace. The stage outputs steer a tree of 2:1 multiplexers that picks the next pair of bits. The slowest stage is also brought out as the word clock. A word is captured when the word clock falls. It waits one word period in a holding stage and is then shifted out.

The reset input is retimed on the falling edge of the half-rate clock. It clears every divider stage and keeps the serial output at 0. A bit-order input selects whether bit 0 or bit 15 of the word goes out first. A gated copy of the half-rate clock is sent alongside the data as a forwarded clock, and a disable input can switch it off.

Top module: `ddr_ser16`

## Requirements
- R1: With `bit_order` = 0 at capture, serial bit i of a word (i = 0 first) equals `par_word[i]`.
- R2: With `bit_order` = 1 at capture, serial bit i equals `par_word[15-i]`, so bit 15 goes out first.
- R3: `word_clk` divides the half-rate clock by 8. Half-rate rising edges after reset release are numbered P = 1, 2, and so on. After edge P, `word_clk` is 1 when P mod 8 is 4 to 7 and 0 otherwise.
- R4: `rst_in` is sampled on the falling edge of `clk_hr`. From the next rising edge on, all divider stages read 0, so `word_clk` is 0 for the whole time reset is held.
- R5: `ser_out` is 0 in both clock phases from the falling edge that samples reset high until data arrives. Data arrives no earlier than the high phase after edge 17 following release.
- R6: A word is captured only at the rising edge where `word_clk` falls, which is P = 8m. Changes to `par_word` at any other time have no effect on the serial stream.
- R7: `bit_order` is sampled only at that capture edge. Changing it between captures never splits a word across two orderings.
- R8: The word captured at edge C starts leaving in the high phase after edge C+9. It takes eight full cycles.
- R9: After edge C+9+k (k = 0..7), the high phase of `clk_hr` carries serial bit 2k and the following low phase carries serial bit 2k+1.
- R10: `fwd_clk` equals `clk_hr` while `fwd_off` = 0. It is held at 0 in both phases while `fwd_off` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hr | input | 1 | Half-rate clock; a bit goes out on each of its edges |
| rst_in | input | 1 | Active-high reset, retimed on the falling edge |
| bit_order | input | 1 | 0: bit 0 first; 1: bit 15 first |
| fwd_off | input | 1 | 1 switches the forwarded clock off |
| par_word | input | 16 | Parallel input word |
| ser_out | output | 1 | Serial data, two bits per half-rate cycle |
| word_clk | output | 1 | Half-rate clock divided by 8 |
| fwd_clk | output | 1 | Forwarded half-rate clock |

## Verification
After each reset release, the bench numbers every half-rate rising edge. It sets a word and its order at P ≡ 4 (mod 8), so they are captured at P = 8m. At P ≡ 1 it drives an inverted decoy word with the opposite order.

It checks `ser_out` 1 ns after each rising edge and 1 ns after each falling edge. The word captured at P = 8m is expected nine edges later, from P = 8m+9 onward. Bit 2k is expected in the high phase and bit 2k+1 in the low phase, so the bench computes word index m = (P-1)/8 - 1 and pair index k = (P-1) mod 8.

`word_clk` is compared with P mod 8 ≥ 4. Reset is asserted in the middle of words. Zeros are expected from the rising edge after the falling edge that samples reset, which is where the retiming takes effect.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Number of divide-by-2 stages in the select chain.
  parameter int SER_DIV_STAGES = 3;

  // Bits per word: two per half-rate cycle, 2**stages cycles per word.
  function automatic int word_bits(input int stages);
    return 2 << stages;
  endfunction

  // Serial index carried in a given phase of pair slot k (phase 0 = high).
  function automatic int serial_index(input int k, input int phase);
    return 2 * k + phase;
  endfunction

endpackage

// File: rtl/ser_divider.sv
module ser_divider #(
  parameter int STAGES = 3
) (
  input  logic              clk_hr,
  input  logic              rst_in,
  output logic              rst_q,
  output logic [STAGES-1:0] sel,
  output logic              load
);
  logic [STAGES:0] carry;

  // Reset retimed on the falling edge before it touches the chain.
  always_ff @(negedge clk_hr) rst_q <= rst_in;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic st_q;
    always_ff @(posedge clk_hr) begin
      if (rst_q) st_q <= 1'b0;
      else if (carry[i]) st_q <= ~st_q;
    end
    assign sel[i]     = st_q;
    assign carry[i+1] = carry[i] & st_q;
  end

  // Last count of a word: the next rising edge makes the slowest stage fall.
  assign load = carry[STAGES] & ~rst_q;

  assert_div_step_R3: assert property (@(posedge clk_hr) disable iff (rst_q)
    1'b1 |=> sel == ($past(sel) + 1'b1));

  assert_div_preset_R4: assert property (@(posedge clk_hr) disable iff (rst_q)
    $fell(rst_q) |-> sel == '0);
endmodule

// File: rtl/ser_word_stage.sv
module ser_word_stage #(
  parameter int W = 16
) (
  input  logic         clk_hr,
  input  logic         rst_q,
  input  logic         load,
  input  logic         bit_order,
  input  logic [W-1:0] par_word,
  output logic [W-1:0] ser_word
);
  logic [W-1:0] hold_q;

  // Arrange the word so that serial index i always sits at position i.
  function automatic logic [W-1:0] orient(input logic [W-1:0] w, input logic rev);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = rev ? w[W-1-i] : w[i];
    return r;
  endfunction

  always_ff @(posedge clk_hr) begin
    if (rst_q) begin
      hold_q   <= '0;
      ser_word <= '0;
    end else if (load) begin
      hold_q   <= orient(par_word, bit_order);
      ser_word <= hold_q;
    end
  end

  assert_hold_between_R6: assert property (@(posedge clk_hr) disable iff (rst_q)
    !load |=> $stable(hold_q) && $stable(ser_word));

  assert_transfer_R8: assert property (@(posedge clk_hr) disable iff (rst_q)
    load |=> ser_word == $past(hold_q));
endmodule

// File: rtl/ser_mux_tree.sv
module ser_mux_tree #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [N-1:0]     leaves,
  input  logic [SEL_W-1:0] sel,
  output logic             pick
);
  // Heap-ordered nodes: node k has children 2k+1 and 2k+2; leaves at the tail.
  logic [2*N-2:0] node;

  assign node[2*N-2:N-1] = leaves;

  for (genvar d = 0; d < SEL_W; d++) begin : g_depth
    for (genvar o = 0; o < (1 << d); o++) begin : g_node
      localparam int K = (1 << d) - 1 + o;
      assign node[K] = sel[SEL_W-1-d] ? node[2*K+2] : node[2*K+1];
    end
  end

  assign pick = node[0];
endmodule

// File: rtl/ser_ddr_out.sv
module ser_ddr_out (
  input  logic clk_hr,
  input  logic rst_q,
  input  logic ev_in,
  input  logic od_in,
  output logic ser_out
);
  logic ev_q, od_stage, od_q;

  always_ff @(posedge clk_hr) begin
    if (rst_q) begin
      ev_q     <= 1'b0;
      od_stage <= 1'b0;
    end else begin
      ev_q     <= ev_in;
      od_stage <= od_in;
    end
  end

  // The odd bit moves to a falling-edge flop so it is steady through the low phase.
  always_ff @(negedge clk_hr) od_q <= od_stage;

  assign ser_out = rst_q ? 1'b0 : (clk_hr ? ev_q : od_q);
endmodule

// File: rtl/ddr_ser16.sv
module ddr_ser16 #(
  parameter int DIV_STAGES = ser_pkg::SER_DIV_STAGES,
  localparam int W = ser_pkg::word_bits(DIV_STAGES),
  localparam int HALF = W / 2
) (
  input  logic         clk_hr,
  input  logic         rst_in,
  input  logic         bit_order,
  input  logic         fwd_off,
  input  logic [W-1:0] par_word,
  output logic         ser_out,
  output logic         word_clk,
  output logic         fwd_clk
);
  logic                  rst_q;
  logic                  load;
  logic [DIV_STAGES-1:0] sel;
  logic [W-1:0]          ser_word;
  logic [HALF-1:0]       ev_leaf, od_leaf;
  logic                  ev_bit, od_bit;

  ser_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk_hr(clk_hr), .rst_in(rst_in), .rst_q(rst_q), .sel(sel), .load(load)
  );

  ser_word_stage #(.W(W)) u_word (
    .clk_hr(clk_hr), .rst_q(rst_q), .load(load), .bit_order(bit_order),
    .par_word(par_word), .ser_word(ser_word)
  );

  for (genvar j = 0; j < HALF; j++) begin : g_lane
    assign ev_leaf[j] = ser_word[ser_pkg::serial_index(j, 0)];
    assign od_leaf[j] = ser_word[ser_pkg::serial_index(j, 1)];
  end

  ser_mux_tree #(.SEL_W(DIV_STAGES)) u_tree_ev (
    .leaves(ev_leaf), .sel(sel), .pick(ev_bit)
  );
  ser_mux_tree #(.SEL_W(DIV_STAGES)) u_tree_od (
    .leaves(od_leaf), .sel(sel), .pick(od_bit)
  );

  ser_ddr_out u_out (
    .clk_hr(clk_hr), .rst_q(rst_q), .ev_in(ev_bit), .od_in(od_bit), .ser_out(ser_out)
  );

  assign word_clk = sel[DIV_STAGES-1];
  assign fwd_clk  = clk_hr & ~fwd_off;

  assert_wordclk_fall_R6: assert property (@(posedge clk_hr) disable iff (rst_q)
    $fell(word_clk) |-> $past(load));

  assert_quiet_reset_R5: assert property (@(posedge clk_hr) disable iff (!rst_q)
    $past(rst_q) |-> ser_out == 1'b0);
endmodule

// File: tb/sim_ddr_ser16.sv
`timescale 1ns/1ps
module sim_ddr_ser16;
  logic        clk_hr, rst_in, bit_order, fwd_off;
  logic [15:0] par_word;
  logic        ser_out, word_clk, fwd_clk;
  int checks = 0, failures = 0;
  logic [15:0] w_tab [0:63];
  logic        o_tab [0:63];

  ddr_ser16 u0 (
    .clk_hr(clk_hr), .rst_in(rst_in), .bit_order(bit_order), .fwd_off(fwd_off),
    .par_word(par_word), .ser_out(ser_out), .word_clk(word_clk), .fwd_clk(fwd_clk)
  );

  initial clk_hr = 1'b1;
  always #2.5 clk_hr = ~clk_hr;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int m, input int salt);
    case (m)
      1: return 16'h0001;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0000;
      default: return 16'((m * 40503 + salt * 977) ^ (m << 5));
    endcase
  endfunction

  // Serial bit s of word m as the requirements define it.
  function automatic logic exp_bit(input int m, input int s);
    return o_tab[m] ? w_tab[m][15-s] : w_tab[m][s];
  endfunction

  task automatic check_reset(input int n);
    rst_in = 1'b1;
    @(posedge clk_hr);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_hr); #1;
      chk(ser_out, 1'b0, "R5 high phase in reset");
      chk(word_clk, 1'b0, "R4 divider preset");
      #2.5;
      chk(ser_out, 1'b0, "R5 low phase in reset");
    end
  endtask

  task automatic run_seg(input int ncyc, input int salt);
    @(posedge clk_hr); #1;
    rst_in = 1'b0;
    for (int p = 1; p <= ncyc; p++) begin
      int m, k;
      logic eh, el;
      @(posedge clk_hr); #1;
      m = (p - 1) / 8 - 1;
      k = (p - 1) % 8;
      eh = (m >= 1) ? exp_bit(m, 2 * k) : 1'b0;
      el = (m >= 1) ? exp_bit(m, 2 * k + 1) : 1'b0;
      if (m < 1) chk(ser_out, 1'b0, "R5 high phase before first word");
      else if (o_tab[m]) chk(ser_out, eh, "R2 R8 R9 high phase reversed");
      else chk(ser_out, eh, "R1 R8 R9 high phase");
      chk(word_clk, 1'((p % 8) >= 4), "R3 word clock");
      chk(fwd_clk, !fwd_off, "R10 forwarded high");
      if (p % 8 == 4) begin
        int mm;
        mm = (p + 4) / 8;
        w_tab[mm] = word_of(mm, salt);
        o_tab[mm] = 1'(((mm + salt) >> 1) & 1);
        par_word  = w_tab[mm];
        bit_order = o_tab[mm];
      end else if (p % 8 == 1 && p > 8) begin
        // decoy between captures: R6 R7 say it must not reach the stream
        par_word  = ~par_word;
        bit_order = ~bit_order;
      end
      #2.5;
      if (m < 1) chk(ser_out, 1'b0, "R5 low phase before first word");
      else if (o_tab[m]) chk(ser_out, el, "R2 R6 R7 R9 low phase reversed");
      else chk(ser_out, el, "R1 R6 R7 R9 low phase");
      chk(fwd_clk, 1'b0, "R10 forwarded low");
      fwd_off = 1'(((p + salt) / 13) % 2);
    end
  endtask

  initial begin
    rst_in = 1'b1; bit_order = 1'b0; fwd_off = 1'b0; par_word = '0;
    for (int i = 0; i < 64; i++) begin w_tab[i] = '0; o_tab[i] = 1'b0; end
    check_reset(4);
    run_seg(200, 1);
    check_reset(5);
    run_seg(171, 2);
    check_reset(3);
    run_seg(261, 3);
    check_reset(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired at %0t: got running expected done", $time);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule